// File: doc/BRIEF.md
# Streaming Matrix-Vector Multiply Engine

This block takes one stream of signed fixed-point words and returns the product of an NxN matrix with an N-element vector. N is picked at run time when the block starts. The vector travels in-band ahead of the matrix. The first N accepted words fill a local vector store. After that come N*N matrix words in row-major order. Each matrix word goes straight into a multiply-accumulate stage, where it is paired with the stored vector element that has the same column index. At the end of each row, the finished dot product goes into a result store. The vector read pointer then goes back to column 0 for the next row. When all rows are done, the N results are streamed out in row order.

A mode bit latched at start can select loopback instead of compute. In loopback the N accepted words are only buffered and then sent back out unchanged, sign-extended to the output width. This gives a cheap way to test the stream path without the arithmetic.

The control is a four-state machine:
- ST_IDLE goes to ST_VEC on an accepted start.
- ST_VEC goes to ST_MAT on the last vector word in compute mode, or to ST_DRAIN on that word in loopback mode.
- ST_MAT goes to ST_DRAIN on the last matrix word.
- ST_DRAIN goes back to ST_IDLE on the last output handshake.

Top module: `mv_engine`

## Requirements
- R1: After reset, busy, in_ready, out_valid and done are all low.
- R2: A start pulse in idle latches size_n and mode_mul (1 = compute, 0 = loopback), and busy is high in the next cycle. Later changes of size_n or mode_mul have no effect on the run in progress.
- R3: In compute mode exactly N + N*N input words are accepted. In loopback mode exactly N words are accepted. After the last one, in_ready stays low until the next run.
- R4: In compute mode output word r (r = 0..N-1, in row order) equals the sum over c of M[r][c]*v[c]. Here v is the first N words and M[r][c] is input word N + r*N + c, all signed two's complement of DATA_W bits. The result is a signed ACC_W-bit value, ACC_W = 2*DATA_W + clog2(MAX_N), so it cannot overflow.
- R5: Cycles with in_valid low stall the vector, column and row counters and leave the results unchanged.
- R6: In loopback mode the N accepted words are emitted in arrival order, sign-extended to ACC_W, with no arithmetic applied.
- R7: While results are being drained, in_ready is low and anything on the input stream is ignored.
- R8: A start while busy is ignored. The run in progress keeps its N and mode.
- R9: done pulses high for one cycle, in the cycle after the last output handshake. busy is low in that same cycle.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R11: Both size limits work: N = 2 and N = MAX_N. This includes the extreme product value when every input word is the most negative code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start | input | 1 | Begin a run (taken only when idle) |
| mode_mul | input | 1 | 1 = compute, 0 = loopback |
| size_n | input | N_W | Run size N, 2..MAX_N |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final output |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | DATA_W | Signed input word |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | ACC_W | Signed result word |

## Verification
The properties assume that start is raised in idle only with size_n in the range 2..MAX_N. They also assume that out_ready is driven from a clean source. Both assumptions matter because the block does not range-check N. The stimulus chooses N from that range whenever it issues a real start. It draws out-of-range or random sizes only for start pulses raised while the block is busy, and those pulses are refused. Random input gaps, output backpressure and junk input words during draining are mixed in, so the properties are exercised under every stall pattern the handshakes allow.

// File: rtl/mv_pkg.sv
package mv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VEC   = 2'd1,
        ST_MAT   = 2'd2,
        ST_DRAIN = 2'd3
    } mv_state_e;
endpackage

// File: rtl/mv_ram.sv
module mv_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mv_mac.sv
module mv_mac #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     first,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [ACC_W-1:0]  sum_next
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] prod_ext;

    assign prod     = a * b;
    assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    assign sum_next = (first ? '0 : acc) + prod_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= sum_next;
    end
endmodule

// File: rtl/mv_engine.sv
module mv_engine
    import mv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MAX_N  = 64,
    localparam int N_W   = $clog2(MAX_N + 1),
    localparam int AW    = $clog2(MAX_N),
    localparam int ACC_W = 2 * DATA_W + $clog2(MAX_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_mul,
    input  logic [N_W-1:0]    size_n,
    output logic              busy,
    output logic              done,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ACC_W-1:0]  out_data
);
    localparam logic [N_W-1:0] ONE = N_W'(1);

    mv_state_e      state, state_nx;
    logic [N_W-1:0] n_q, col, row;
    logic           mode_q, done_q;
    logic           in_hs, out_hs, last_col, last_row;
    logic [DATA_W-1:0] vec_rd;
    logic [ACC_W-1:0]  res_rd, mac_sum;

    assign in_hs    = in_valid && in_ready;
    assign out_hs   = out_valid && out_ready;
    assign last_col = (col == n_q - ONE);
    assign last_row = (row == n_q - ONE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_VEC;
            ST_VEC:   if (in_hs && last_col) state_nx = mode_q ? ST_MAT : ST_DRAIN;
            ST_MAT:   if (in_hs && last_col && last_row) state_nx = ST_DRAIN;
            ST_DRAIN: if (out_hs && last_col) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        in_ready  = (state == ST_VEC) || (state == ST_MAT);
        out_valid = (state == ST_DRAIN);
        done      = done_q;
        out_data  = mode_q ? res_rd : {{(ACC_W-DATA_W){vec_rd[DATA_W-1]}}, vec_rd};
    end

    // counters and run parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= '0;
            mode_q <= 1'b0;
            col    <= '0;
            row    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state == ST_DRAIN) && out_hs && last_col;
            unique case (state)
                ST_IDLE: begin
                    col <= '0;
                    row <= '0;
                    if (start) begin
                        n_q    <= size_n;
                        mode_q <= mode_mul;
                    end
                end
                ST_VEC: if (in_hs) col <= last_col ? '0 : col + ONE;
                ST_MAT: if (in_hs) begin
                    if (last_col) begin
                        col <= '0;
                        row <= row + ONE;
                    end else begin
                        col <= col + ONE;
                    end
                end
                ST_DRAIN: if (out_hs) col <= col + ONE;
                default: col <= '0;
            endcase
        end
    end

    mv_ram #(.W(DATA_W), .DEPTH(MAX_N)) u_vec_ram (
        .clk   (clk),
        .we    ((state == ST_VEC) && in_hs),
        .waddr (col[AW-1:0]),
        .wdata (in_data),
        .raddr (col[AW-1:0]),
        .rdata (vec_rd)
    );

    mv_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       ((state == ST_MAT) && in_hs),
        .first    (col == '0),
        .a        (in_data),
        .b        (vec_rd),
        .sum_next (mac_sum)
    );

    mv_ram #(.W(ACC_W), .DEPTH(MAX_N)) u_res_ram (
        .clk   (clk),
        .we    ((state == ST_MAT) && in_hs && last_col),
        .waddr (row[AW-1:0]),
        .wdata (mac_sum),
        .raddr (col[AW-1:0]),
        .rdata (res_rd)
    );
endmodule

// File: rtl/mv_engine_chk.sv
module mv_engine_chk #(
    parameter int N_W   = 7,
    parameter int ACC_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ACC_W-1:0] out_data
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_no_input_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind mv_engine mv_engine_chk #(.N_W(N_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_mv_engine.sv
module sim_mv_engine;
    localparam int DATA_W = 8;
    localparam int MAX_N  = 64;
    localparam int N_W    = $clog2(MAX_N + 1);
    localparam int ACC_W  = 2 * DATA_W + $clog2(MAX_N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode_mul = 1'b0;
    logic [N_W-1:0] size_n = '0;
    logic busy, done, in_ready, out_valid;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [ACC_W-1:0]  out_data;

    int total = 0, bad = 0;
    int vec [MAX_N];
    int mat [MAX_N*MAX_N];
    longint expv [MAX_N];
    bit fill_min = 1'b0;

    always #2 clk = ~clk;

    mv_engine #(.DATA_W(DATA_W), .MAX_N(MAX_N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_mul(mode_mul),
        .size_n(size_n), .busy(busy), .done(done), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd_word();
        return fill_min ? -(1 << (DATA_W-1)) : int'($urandom_range(0, (1 << DATA_W) - 1)) - (1 << (DATA_W-1));
    endfunction

    task automatic run_case(input int n, input bit mul, input int stall, input int bp, input bit spam);
        int words, i, o, guard;
        bit fin, pend, extra_ok;
        longint s;
        words = mul ? n + n*n : n;
        for (int k = 0; k < n; k++) vec[k] = rnd_word();
        if (mul) for (int k = 0; k < n*n; k++) mat[k] = rnd_word();
        for (int r = 0; r < n; r++) begin
            if (mul) begin
                s = 0;
                for (int c = 0; c < n; c++) s += longint'(mat[r*n+c]) * longint'(vec[c]);
                expv[r] = s;
            end else expv[r] = vec[r];
        end
        @(negedge clk);
        size_n = N_W'(n); mode_mul = mul; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", busy, 1);
        size_n = N_W'($urandom_range(2, MAX_N)); mode_mul = ~mul;   // R2: must be ignored
        i = 0; o = 0; fin = 0; pend = 0; guard = 0; extra_ok = 1;
        while (!fin && guard < 40000) begin
            if (pend) begin
                start = 1'b0;
                check(done === 1'b1 && busy === 1'b0, "R9 done pulse, busy low", {done, busy}, 2);
                fin = 1;
            end else begin
                if (done !== 1'b0) check(0, "R9 early done", done, 0);
                if (i < words) begin
                    in_valid = ($urandom_range(0, 99) >= stall);
                    in_data  = DATA_W'((i < n) ? vec[i] : mat[i-n]);
                end else begin
                    in_valid = $urandom_range(0, 1);          // R7 junk while draining
                    in_data  = DATA_W'($urandom);
                end
                out_ready = ($urandom_range(0, 99) >= bp);
                if (spam) begin                              // R8 refused starts
                    start  = ($urandom_range(0, 9) == 0);
                    size_n = N_W'($urandom);
                end
                if (in_valid && in_ready) begin
                    if (i >= words) extra_ok = 0;
                    i++;
                end
                if (out_valid && in_ready) check(0, "R7 in_ready during drain", 1, 0);
                if (out_valid && out_ready) begin
                    check($signed(out_data) == expv[o], mul ? "R4/R5/R8 result word" : "R6 loopback word",
                          longint'($signed(out_data)), expv[o]);
                    o++;
                    if (o == n) pend = 1;
                end
                @(negedge clk);
                guard++;
            end
        end
        start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        check(fin, "R9 run completed", fin, 1);
        check(extra_ok && i == words, "R3 accepted word count", i, words);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(busy === 0 && in_ready === 0 && out_valid === 0 && done === 0,
              "R1 reset outputs", {busy, in_ready, out_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && in_ready === 0 && out_valid === 0 && done === 0,
              "R1 idle after reset", {busy, in_ready, out_valid, done}, 0);
        run_case(2, 1, 0, 0, 0);            // R11 smallest N, no stalls
        run_case(2, 0, 0, 0, 0);            // R6 loopback, smallest N
        fill_min = 1'b1;
        run_case(MAX_N, 1, 0, 0, 0);        // R11 largest N, extreme product
        fill_min = 1'b0;
        run_case(MAX_N, 1, 30, 40, 1);      // R5 R8 R10 stalls/backpressure
        run_case(MAX_N, 0, 20, 50, 1);      // R6 loopback at largest N
        for (int t = 0; t < 12; t++)
            run_case($urandom_range(2, 12), $urandom_range(0, 1), $urandom_range(0, 60),
                     $urandom_range(0, 60), $urandom_range(0, 1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule